// File: doc/BRIEF.md
# Machine-Mode Trap Entry and Return Controller

This block sits beside the fetch stage of a single-hart, machine-mode-only core. Each cycle it looks at the instruction at the commit point, the interrupt request lines, the exception flags raised for that instruction and an mret strobe. From these it decides whether control leaves the normal flow. When a trap is taken, it issues a program-counter redirect to the trap base held in mtvec. In the same registered cycle it produces write strobes and data for mepc, mcause and mstatus, so the register file outside the block can save the return address, the cause and the interrupt-enable history.

On an mret it redirects to the address held in mepc and restores the global interrupt enable from its saved copy. Software does the register save and restore in the handler, and it reads mcause to learn why it was entered. Only direct mode is supported: every trap goes to the same base address.

All outputs are registered. A decision made on the inputs of cycle t shows at the ports after the clock edge that ends cycle t. The cycle in which a redirect is presented is treated as a flush slot: the instruction in flight is being discarded, so nothing seen in that cycle can start another event. Out of reset the block presents a redirect to the reset address, which is distinct from the trap base.

Top module: `trap_ctrl`

## Requirements
- R1: While reset is asserted, redir_valid_o is 1, redir_addr_o is RESET_VEC (default 0x0000_0000) and all three write strobes are 0. The first cycle after reset is released is a flush slot under R10.
- R2: A taken trap produces, one clock later and all in the same cycle, the following: redir_valid_o=1, redir_addr_o equal to mtvec_i with bits [1:0] forced to zero, and mepc_we_o, mcause_we_o and mstatus_we_o all 1.
- R3: An interrupt line is taken only when three things hold: the line is high, its enable bit in mie_i is set, and mstatus_i bit 3 (global enable) is 1. The line-to-mie-bit mapping is irq_i[0]→bit 11, irq_i[1]→bit 3, irq_i[2]→bit 7.
- R4: Among enabled interrupts the lowest irq_i index wins (external, then software, then timer). mcause is written with bit 31 set and the low bits holding 11, 3 or 7 respectively.
- R5: Exceptions are taken regardless of the global enable and win over interrupts. The flag-to-cause mapping is exc_i[0]→0 (misaligned fetch), exc_i[1]→2 (illegal instruction), exc_i[2]→3 (breakpoint), exc_i[3]→11 (environment call); the lowest index wins. mcause bit 31 is 0.
- R6: mepc is written with next_pc_i for an interrupt and with cur_pc_i for an exception.
- R7: On trap entry the mstatus write data copies bit 3 into bit 7, clears bit 3, sets bits [12:11] to 2'b11 and leaves all other bits as read.
- R8: An mret with no trap pending redirects to mepc_i with bits [1:0] forced to zero. It writes mstatus with bit 3 taken from bit 7, bit 7 set, bits [12:11] set to 2'b11 and all other bits unchanged. mepc and mcause are not written.
- R9: A trap and an mret in the same cycle resolve as the trap alone.
- R10: In any cycle where redir_valid_o is 1, all inputs are ignored. The following cycle shows no redirect and no write strobe.
- R11: With no trap and no mret, the next cycle shows no redirect and no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cur_pc_i | input | 32 | Address of the instruction at the commit point |
| next_pc_i | input | 32 | Address of the next instruction not yet executed |
| irq_i | input | 3 | Interrupt request lines: external, software, timer |
| exc_i | input | 4 | Exception flags for the current instruction |
| mret_i | input | 1 | Current instruction is an mret |
| mie_i | input | 32 | Current interrupt-enable mask register |
| mstatus_i | input | 32 | Current machine status register |
| mtvec_i | input | 32 | Current trap base register |
| mepc_i | input | 32 | Current saved exception PC register |
| redir_valid_o | output | 1 | Redirect the fetch PC this cycle |
| redir_addr_o | output | 32 | Redirect target |
| mepc_we_o | output | 1 | Write strobe for mepc |
| mepc_wdata_o | output | 32 | Value for mepc |
| mcause_we_o | output | 1 | Write strobe for mcause |
| mcause_wdata_o | output | 32 | Value for mcause |
| mstatus_we_o | output | 1 | Write strobe for mstatus |
| mstatus_wdata_o | output | 32 | Value for mstatus |

## Verification
The bench sweeps every combination of the three request lines, their three mask bits, the global enable, the four exception flags and the mret strobe. Each case runs with distinct PC, vector and status patterns and is followed by an observation of the slot after it.

Several faults are targeted. If the global enable or a mask bit were ignored, interrupts would be taken while masked. A swapped priority would show the wrong code in mcause or the wrong type bit. If the type of trap were mixed up, mepc would hold the next address for a faulting instruction, or the reverse. Letting mret win over a trap would lose the trap.

The bench also drives every source high during each flush slot. A design that did not hold off there would raise a second trap back to back. Low bits of mtvec and mepc are set in many cases, so a missing alignment mask shows up as a misaligned target.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int XLEN      = 32;
    localparam int CODE_W    = 5;
    localparam int NUM_IRQ   = 3;
    localparam int NUM_EXC   = 4;
    localparam int ALIGN_W   = 2;

    // machine status bit positions
    localparam int ST_GIE    = 3;
    localparam int ST_PGIE   = 7;
    localparam int ST_PPRV   = 11;

    // cause code of each interrupt line, indexed by priority (0 highest)
    function automatic logic [CODE_W-1:0] irq_code(input int idx);
        case (idx)
            0:       irq_code = CODE_W'(11);
            1:       irq_code = CODE_W'(3);
            default: irq_code = CODE_W'(7);
        endcase
    endfunction

    // cause code of each exception flag, indexed by priority (0 highest)
    function automatic logic [CODE_W-1:0] exc_code(input int idx);
        case (idx)
            0:       exc_code = CODE_W'(0);
            1:       exc_code = CODE_W'(2);
            2:       exc_code = CODE_W'(3);
            default: exc_code = CODE_W'(11);
        endcase
    endfunction

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_TRAP = 2'd1,
        EV_RET  = 2'd2
    } event_e;

    typedef struct packed {
        logic            redir;
        logic [XLEN-1:0] redir_addr;
        logic            epc_we;
        logic [XLEN-1:0] epc;
        logic            cause_we;
        logic [XLEN-1:0] cause;
        logic            stat_we;
        logic [XLEN-1:0] stat;
    } ctl_state_t;

endpackage

// File: rtl/trap_irq_arb.sv
module trap_irq_arb
    import trap_pkg::*;
(
    input  logic [NUM_IRQ-1:0] req_i,
    input  logic [XLEN-1:0]    mask_i,
    input  logic               gie_i,
    output logic               take_o,
    output logic [CODE_W-1:0]  code_o
);

    logic [NUM_IRQ-1:0] armed;

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_arm
        localparam logic [CODE_W-1:0] BITPOS = irq_code(k);
        assign armed[k] = req_i[k] & mask_i[BITPOS] & gie_i;
    end

    always_comb begin
        code_o = '0;
        for (int k = NUM_IRQ - 1; k >= 0; k--) begin
            if (armed[k]) begin
                code_o = irq_code(k);
            end
        end
    end

    assign take_o = |armed;

    // R3: nothing can be taken with the global enable low
    always_comb begin
        a_r3_gated_by_gie : assert (gie_i || !take_o);
    end

endmodule

// File: rtl/trap_exc_arb.sv
module trap_exc_arb
    import trap_pkg::*;
(
    input  logic [NUM_EXC-1:0] flag_i,
    output logic               take_o,
    output logic [CODE_W-1:0]  code_o
);

    always_comb begin
        code_o = '0;
        for (int k = NUM_EXC - 1; k >= 0; k--) begin
            if (flag_i[k]) begin
                code_o = exc_code(k);
            end
        end
    end

    assign take_o = |flag_i;

endmodule

// File: rtl/trap_stat_upd.sv
module trap_stat_upd
    import trap_pkg::*;
(
    input  logic [XLEN-1:0] stat_i,
    input  logic            is_ret_i,
    output logic [XLEN-1:0] stat_o
);

    always_comb begin
        stat_o = stat_i;
        stat_o[ST_PPRV +: 2] = 2'b11;
        if (is_ret_i) begin
            stat_o[ST_GIE]  = stat_i[ST_PGIE];
            stat_o[ST_PGIE] = 1'b1;
        end else begin
            stat_o[ST_PGIE] = stat_i[ST_GIE];
            stat_o[ST_GIE]  = 1'b0;
        end
    end

endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_VEC = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [XLEN-1:0]    cur_pc_i,
    input  logic [XLEN-1:0]    next_pc_i,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic [NUM_EXC-1:0] exc_i,
    input  logic               mret_i,
    input  logic [XLEN-1:0]    mie_i,
    input  logic [XLEN-1:0]    mstatus_i,
    input  logic [XLEN-1:0]    mtvec_i,
    input  logic [XLEN-1:0]    mepc_i,
    output logic               redir_valid_o,
    output logic [XLEN-1:0]    redir_addr_o,
    output logic               mepc_we_o,
    output logic [XLEN-1:0]    mepc_wdata_o,
    output logic               mcause_we_o,
    output logic [XLEN-1:0]    mcause_wdata_o,
    output logic               mstatus_we_o,
    output logic [XLEN-1:0]    mstatus_wdata_o
);

    localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'((1 << ALIGN_W) - 1);

    ctl_state_t s_d, s_q;

    logic              irq_take, exc_take;
    logic [CODE_W-1:0] irq_cause, exc_cause;
    logic [XLEN-1:0]   stat_upd;
    logic              flush;
    event_e            ev;

    trap_irq_arb u_irq (
        .req_i  (irq_i),
        .mask_i (mie_i),
        .gie_i  (mstatus_i[ST_GIE]),
        .take_o (irq_take),
        .code_o (irq_cause)
    );

    trap_exc_arb u_exc (
        .flag_i (exc_i),
        .take_o (exc_take),
        .code_o (exc_cause)
    );

    trap_stat_upd u_stat (
        .stat_i   (mstatus_i),
        .is_ret_i (ev == EV_RET),
        .stat_o   (stat_upd)
    );

    assign flush = s_q.redir;

    always_comb begin
        ev = EV_NONE;
        if (!flush) begin
            if (exc_take || irq_take) begin
                ev = EV_TRAP;
            end else if (mret_i) begin
                ev = EV_RET;
            end
        end
    end

    always_comb begin
        s_d = '0;
        case (ev)
            EV_TRAP: begin
                s_d.redir      = 1'b1;
                s_d.redir_addr = mtvec_i & ALIGN_MASK;
                s_d.epc_we     = 1'b1;
                s_d.epc        = exc_take ? cur_pc_i : next_pc_i;
                s_d.cause_we   = 1'b1;
                s_d.cause      = exc_take ? {1'b0, (XLEN-1)'(exc_cause)}
                                          : {1'b1, (XLEN-1)'(irq_cause)};
                s_d.stat_we    = 1'b1;
                s_d.stat       = stat_upd;
            end
            EV_RET: begin
                s_d.redir      = 1'b1;
                s_d.redir_addr = mepc_i & ALIGN_MASK;
                s_d.stat_we    = 1'b1;
                s_d.stat       = stat_upd;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q            <= '0;
            s_q.redir      <= 1'b1;
            s_q.redir_addr <= RESET_VEC;
        end else begin
            s_q <= s_d;
        end
    end

    assign redir_valid_o   = s_q.redir;
    assign redir_addr_o    = s_q.redir_addr;
    assign mepc_we_o       = s_q.epc_we;
    assign mepc_wdata_o    = s_q.epc;
    assign mcause_we_o     = s_q.cause_we;
    assign mcause_wdata_o  = s_q.cause;
    assign mstatus_we_o    = s_q.stat_we;
    assign mstatus_wdata_o = s_q.stat;

    // R2: the saved PC always goes out with a redirect to the aligned trap base
    a_r2_epc_with_vector : assert property (@(posedge clk) disable iff (!rst_n)
        mepc_we_o |-> (redir_valid_o && mcause_we_o && mstatus_we_o));

    // R3: no interrupt is taken while the global enable is low
    a_r3_masked_no_irq : assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid_o && !mstatus_i[ST_GIE] && exc_i == '0) |=> !mcause_we_o);

    // R6: an exception saves the faulting address
    a_r6_exc_saves_cur : assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid_o && exc_i != '0) |=> (mepc_wdata_o == $past(cur_pc_i)));

    // R7: entry always leaves the global enable cleared
    a_r7_entry_clears_gie : assert property (@(posedge clk) disable iff (!rst_n)
        mcause_we_o |-> !mstatus_wdata_o[ST_GIE]);

    // R8: a plain mret goes to the aligned saved address
    a_r8_ret_target : assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid_o && mret_i && !exc_take && !irq_take)
        |=> (redir_addr_o == ($past(mepc_i) & ALIGN_MASK) && !mepc_we_o));

    // R9: a trap beside an mret is still recorded
    a_r9_trap_over_ret : assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid_o && mret_i && (exc_take || irq_take)) |=> mcause_we_o);

    // R10: the slot holding a redirect cannot start a new event
    a_r10_flush_slot : assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid_o |=> (!redir_valid_o && !mstatus_we_o));

endmodule

// File: tb/trap_ctrl_tb.sv
module trap_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc, next_pc, mie, mstatus, mtvec, mepc;
    logic [2:0]  irq;
    logic [3:0]  exc;
    logic        mret;
    logic        redir_valid, mepc_we, mcause_we, mstatus_we;
    logic [31:0] redir_addr, mepc_wdata, mcause_wdata, mstatus_wdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    trap_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cur_pc_i(cur_pc), .next_pc_i(next_pc),
        .irq_i(irq), .exc_i(exc), .mret_i(mret), .mie_i(mie),
        .mstatus_i(mstatus), .mtvec_i(mtvec), .mepc_i(mepc),
        .redir_valid_o(redir_valid), .redir_addr_o(redir_addr),
        .mepc_we_o(mepc_we), .mepc_wdata_o(mepc_wdata),
        .mcause_we_o(mcause_we), .mcause_wdata_o(mcause_wdata),
        .mstatus_we_o(mstatus_we), .mstatus_wdata_o(mstatus_wdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic drive_idle();
        irq = '0; exc = '0; mret = 1'b0;
        mie = '0; mstatus = '0; mtvec = 32'h0000_0100; mepc = '0;
        cur_pc = 32'h40; next_pc = 32'h44;
    endtask

    task automatic drive_hot();
        irq = '1; exc = '1; mret = 1'b1;
        mie = '1; mstatus = '1; mtvec = 32'hFFFF_FFFF; mepc = 32'hFFFF_FFFF;
    endtask

    task automatic quiet_check(input string tag);
        chk(tag, {28'd0, redir_valid, mepc_we, mcause_we, mstatus_we}, 32'd0);
    endtask

    initial begin
        drive_idle();
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk("R1 reset redirect/strobes",
            {28'd0, redir_valid, mepc_we, mcause_we, mstatus_we}, 32'h8);
        chk("R1 reset address", redir_addr, 32'h0);
        drive_hot();
        rst_n = 1'b1;
        @(negedge clk);
        // R1/R10: first cycle after reset ignores even fully active inputs
        quiet_check("R1 R10 first slot after reset");
        drive_idle();
        @(negedge clk);
        quiet_check("R11 idle");

        for (int c = 0; c < 4096; c++) begin
            logic [2:0]  l_irq, l_en, armed;
            logic [3:0]  l_exc;
            logic        l_gie, l_ret, is_exc, is_irq, is_ret;
            logic [31:0] e_addr, e_epc, e_cause, e_stat;
            logic [3:0]  e_we;
            logic [4:0]  code;
            string       tg;

            l_irq = c[2:0]; l_en = c[5:3]; l_gie = c[6]; l_exc = c[10:7]; l_ret = c[11];
            irq = l_irq; exc = l_exc; mret = l_ret;
            cur_pc  = 32'h0000_1000 + 32'(c) * 4;
            next_pc = cur_pc + 4;
            mtvec   = 32'h8000_0000 | (32'(c) << 3) | 32'(c & 3);
            mepc    = 32'h0002_0000 + 32'(c) * 4 + 32'((c >> 2) & 3);
            mie     = ((32'(c) * 32'h0001_3579) & ~32'h0000_0888)
                      | {20'd0, l_en[0], 3'd0, l_en[2], 3'd0, l_en[1], 3'd0};
            mstatus = ((32'(c) * 32'h9E37_79B9) & ~32'h0000_0088)
                      | {24'd0, c[1], 3'd0, l_gie, 3'd0};

            // expected values from R2..R9
            armed  = l_irq & l_en & {3{l_gie}};
            is_exc = (l_exc != 0);
            is_irq = !is_exc && (armed != 0);
            is_ret = !is_exc && !is_irq && l_ret;
            code = 5'd0;
            if (is_exc) begin
                if (l_exc[0]) code = 5'd0;
                else if (l_exc[1]) code = 5'd2;
                else if (l_exc[2]) code = 5'd3;
                else code = 5'd11;
            end else if (is_irq) begin
                if (armed[0]) code = 5'd11;
                else if (armed[1]) code = 5'd3;
                else code = 5'd7;
            end
            e_cause = {is_irq, 26'd0, code};
            e_epc   = is_exc ? cur_pc : next_pc;
            e_stat  = mstatus;
            e_stat[12:11] = 2'b11;
            if (is_ret) begin
                e_stat[3] = mstatus[7];
                e_stat[7] = 1'b1;
            end else begin
                e_stat[7] = mstatus[3];
                e_stat[3] = 1'b0;
            end
            e_addr = is_ret ? (mepc & ~32'h3) : (mtvec & ~32'h3);
            if (is_exc || is_irq) e_we = 4'b1111;
            else if (is_ret)      e_we = 4'b1001;
            else                  e_we = 4'b0000;

            if (is_exc)      tg = (l_ret ? "R5 R9" : "R5");
            else if (is_irq) tg = (l_ret ? "R3 R4 R9" : "R3 R4");
            else if (is_ret) tg = "R8";
            else             tg = "R3 R11";

            @(negedge clk);
            chk({tg, " R2 strobes"}, {28'd0, redir_valid, mepc_we, mcause_we, mstatus_we},
                {28'd0, e_we});
            if (e_we[3]) chk({tg, " R2 target"}, redir_addr, e_addr);
            if (e_we[1]) chk({tg, " cause"}, mcause_wdata, e_cause);
            if (e_we[2]) chk({tg, " R6 saved pc"}, mepc_wdata, e_epc);
            if (e_we[0]) chk({tg, (is_ret ? " R8 status" : " R7 status")}, mstatus_wdata, e_stat);

            if (e_we[3]) drive_hot();
            else drive_idle();
            @(negedge clk);
            quiet_check(e_we[3] ? "R10 flush slot" : "R11 idle");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule